// File: doc/BRIEF.md
# Quadrature Position Counter with Modulus

This block tracks the position of an incremental encoder whose phase, index and home signals have already been filtered and synchronised to the block clock. A 32-bit two's-complement position counter follows the encoder. Beside it run a 16-bit revolution counter and a 16-bit position-difference counter that accumulates motion between reads. All configuration arrives on ports: counting mode, direction sense, modulus bounds, reload value, compare value, revolution source and the edge selects for the index and home inputs.

Counting can wrap between a lower bound (the initial value) and an upper bound (the modulus value). Upward and downward wraps raise their own status flags. The index or home input can reload the position on a chosen edge. A compare output pulses on a position match or on a counter read. Five sticky status flags, cleared by writing ones, are gated by per-flag enables onto a single interrupt line. A read strobe on the position copies the position, difference and revolution counts into hold registers in the same clock edge.

Every counter and flag updates on the clock edge that samples the causing input, so outputs change one cycle after an input changes. The compare pulse appears one cycle after the position reaches the compare value.

Top module: `qpos_counter`

## Requirements
- R1: With `cfg_stepdir`=0 and `cfg_reverse`=0, the (A,B) state walk 00→10→11→01→00 adds one to `position` per step, and the reverse walk subtracts one per step. The new count is visible the cycle after the phase change.
- R2: A sample where both A and B differ from the previous sample leaves `position` and `pos_diff` unchanged.
- R3: With `cfg_stepdir`=1, every edge on A (rising or falling) counts once: up when B is low, down when B is high. A change of B alone does not count.
- R4: `cfg_reverse`=1 swaps the sense of counting in both modes, so a walk that would count up counts down.
- R5: With `cfg_mod_en`=1, an up-count from `position`==`cfg_mod` loads `cfg_init` and sets flag bit 3 (roll-over). A down-count from `position`==`cfg_init` loads `cfg_mod` and sets flag bit 4 (roll-under). With `cfg_mod_en`=0 the count wraps over 32 bits: all-ones to zero sets bit 3, and zero to all-ones sets bit 4.
- R6: With `cfg_rev_src`=0, each rising edge of the index input steps `revolution` up when `last_dir`=1 and down otherwise, whatever the index trigger mode. With `cfg_rev_src`=1, a roll-over steps it up and a roll-under steps it down.
- R7: The index and home trigger modes (`cfg_idx_mode`, `cfg_home_mode`) are encoded 0 = off, 1 = rising edge, 2 = falling edge. The selected edge loads `cfg_init` into `position` and sets flag bit 1 (index) or bit 0 (home). The other edge, or mode 0, does nothing.
- R8: With `cfg_match_on_read`=0, `posmatch` is high for exactly one cycle, in the cycle after `position` becomes equal to `cfg_cmp`, and flag bit 2 sets with it.
- R9: With `cfg_match_on_read`=1, `posmatch` is high for one cycle after each cycle in which `rd_pos` or `rd_diff` is high, and flag bit 2 sets with it.
- R10: Flags stay set until a one is written to the matching bit of `flag_clr`. A set event wins over a clear in the same cycle. `irq` is high whenever any flag is set together with its bit of `irq_en`.
- R11: `last_dir` is 1 after an up-count and 0 after a down-count, and holds between counts.
- R12: `rd_pos` copies the `position`, `pos_diff` and `revolution` values present in that cycle into `hold_pos`, `hold_diff` and `hold_rev`, even when a count happens in the same cycle.
- R13: `pos_diff` accumulates signed counts. `rd_diff` restarts it, so after a read it holds only the count (−1, 0 or +1) of the read cycle itself.
- R14: `sw_init` loads `cfg_init` into `position` and clears `revolution`. It takes priority over a count or a trigger reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Filtered phase A |
| enc_b | input | 1 | Filtered phase B |
| enc_idx | input | 1 | Filtered index input |
| enc_home | input | 1 | Filtered home input |
| cfg_reverse | input | 1 | Swap counting sense |
| cfg_stepdir | input | 1 | 1 = A is a count strobe and B sets direction |
| cfg_mod_en | input | 1 | Enable modulus wrapping |
| cfg_rev_src | input | 1 | Revolution source: 0 index, 1 modulus wrap |
| cfg_match_on_read | input | 1 | Compare pulse source: 0 equality, 1 counter read |
| cfg_idx_mode | input | 2 | Index trigger edge: 0 off, 1 rising, 2 falling |
| cfg_home_mode | input | 2 | Home trigger edge: 0 off, 1 rising, 2 falling |
| cfg_init | input | 32 | Reload value and lower modulus bound |
| cfg_mod | input | 32 | Upper modulus bound |
| cfg_cmp | input | 32 | Compare value |
| irq_en | input | 5 | Per-flag interrupt enables |
| sw_init | input | 1 | Software initialise strobe |
| rd_pos | input | 1 | Position read strobe, captures hold registers |
| rd_diff | input | 1 | Difference read strobe, restarts difference count |
| flag_clr | input | 5 | Write-one-to-clear mask for the flags |
| position | output | 32 | Position counter |
| revolution | output | 16 | Revolution counter |
| pos_diff | output | 16 | Difference counter |
| hold_pos | output | 32 | Captured position |
| hold_rev | output | 16 | Captured revolution |
| hold_diff | output | 16 | Captured difference |
| last_dir | output | 1 | Direction of last count, 1 = up |
| posmatch | output | 1 | Compare pulse |
| flags | output | 5 | Sticky flags: 0 home, 1 index, 2 compare, 3 roll-over, 4 roll-under |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives jumps where both phases change at once. A decoder that treats these as double steps would drift the count. Modulus wraps are exercised at both bounds and across the plain 32-bit boundary. A wrong bound comparison would overshoot to `cfg_mod`+1 or miss the flag. Same-cycle collisions are forced on purpose: a set against a clear of one flag, a read against a count, and an initialise against a count. A design with the wrong priority would lose a flag, capture the post-count value, or load `cfg_init`+1. The index input is also toggled under each trigger mode, with both directions of last motion. This catches reloads on the wrong edge and revolution steps that ignore direction.

// File: rtl/qpos_pkg.sv
// Package: shared constants for the quadrature position counter.
// Assumes all users share one flag layout; flag bit positions are visible
// at the block's ports and must not move.
package qpos_pkg;

    localparam int NUM_FLAGS = 5;
    localparam int FLG_HOME  = 0;
    localparam int FLG_INDEX = 1;
    localparam int FLG_CMP   = 2;
    localparam int FLG_ROVR  = 3;
    localparam int FLG_RUND  = 4;

    // Trigger channels, numbered to match the flag bit they set.
    localparam int NUM_TRIG  = 2;
    localparam int TRG_HOME  = 0;
    localparam int TRG_INDEX = 1;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_FALL = 2'd2
    } trig_mode_e;

endpackage

// File: rtl/qpos_step_decode.sv
// Module: turns phase A/B samples into single up/down count strobes.
// Assumes the phases are already filtered and synchronous to clk.
// Quadrature mode: Gray-code walk 00->10->11->01 is up; a double change
// is illegal and produces no strobe. Step/direction mode: any A edge
// counts, B low = up. Reverse swaps the two strobes.
module qpos_step_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_a,
    input  logic enc_b,
    input  logic cfg_stepdir,
    input  logic cfg_reverse,
    output logic step_up,
    output logic step_dn
);

    logic       a_q, b_q;
    logic [1:0] old_ph, new_ph, ph_delta;
    logic       raw_up, raw_dn;

    // Remember the previous phase sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= enc_a;
            b_q <= enc_b;
        end
    end

    // Map each Gray state to a 0..3 phase index and classify the move.
    always_comb begin
        old_ph   = {b_q, a_q ^ b_q};
        new_ph   = {enc_b, enc_a ^ enc_b};
        ph_delta = new_ph - old_ph;
        if (cfg_stepdir) begin
            raw_up = (enc_a != a_q) && !enc_b;
            raw_dn = (enc_a != a_q) &&  enc_b;
        end else begin
            raw_up = (ph_delta == 2'd1);
            raw_dn = (ph_delta == 2'd3);
        end
        step_up = cfg_reverse ? raw_dn : raw_up;
        step_dn = cfg_reverse ? raw_up : raw_dn;
    end

    // R1: never both directions in one cycle.
    assert_one_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));

    // R2: a double phase change in quadrature mode yields no count.
    assert_illegal_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_stepdir && (enc_a != a_q) && (enc_b != b_q)) |-> (!step_up && !step_dn));

endmodule

// File: rtl/qpos_edge_det.sv
// Module: rising/falling edge detector for one trigger input.
// Assumes the input is synchronous to clk; reports edges in the cycle the
// new level is first sampled.
module qpos_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);

    logic sig_q;

    // Hold the previous level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    // Compare current and previous levels.
    always_comb begin
        rise = sig & ~sig_q;
        fall = ~sig & sig_q;
    end

    // Both edges at once is impossible.
    assert_edge_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

endmodule

// File: rtl/qpos_core.sv
// Module: position, revolution and difference counters plus hold registers.
// Assumes step_up/step_dn are exclusive. Priority for the position:
// software initialise, then trigger reload, then count. Roll events are
// reported only when a count actually wraps (not when overridden).
module qpos_core #(
    parameter int POS_W  = 32,
    parameter int REV_W  = 16,
    parameter int DIFF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_up,
    input  logic              step_dn,
    input  logic              trig_load,
    input  logic              idx_rise,
    input  logic              sw_init,
    input  logic              rd_pos,
    input  logic              rd_diff,
    input  logic              cfg_mod_en,
    input  logic              cfg_rev_src,
    input  logic [POS_W-1:0]  cfg_init,
    input  logic [POS_W-1:0]  cfg_mod,
    output logic [POS_W-1:0]  position,
    output logic [REV_W-1:0]  revolution,
    output logic [DIFF_W-1:0] pos_diff,
    output logic [POS_W-1:0]  hold_pos,
    output logic [REV_W-1:0]  hold_rev,
    output logic [DIFF_W-1:0] hold_diff,
    output logic              last_dir,
    output logic              roll_over,
    output logic              roll_under
);

    logic [POS_W-1:0]  nxt_pos;
    logic [REV_W-1:0]  nxt_rev;
    logic [DIFF_W-1:0] step_val, nxt_diff;

    // Next position with modulus or plain wrap, then reload overrides.
    always_comb begin
        nxt_pos    = position;
        roll_over  = 1'b0;
        roll_under = 1'b0;
        if (step_up) begin
            if (cfg_mod_en && (position == cfg_mod)) begin
                nxt_pos   = cfg_init;
                roll_over = 1'b1;
            end else begin
                nxt_pos   = position + POS_W'(1);
                roll_over = !cfg_mod_en && (position == '1);
            end
        end else if (step_dn) begin
            if (cfg_mod_en && (position == cfg_init)) begin
                nxt_pos    = cfg_mod;
                roll_under = 1'b1;
            end else begin
                nxt_pos    = position - POS_W'(1);
                roll_under = !cfg_mod_en && (position == '0);
            end
        end
        if (sw_init || trig_load) begin
            nxt_pos    = cfg_init;
            roll_over  = 1'b0;
            roll_under = 1'b0;
        end
    end

    // Next revolution count from the selected source.
    always_comb begin
        nxt_rev = revolution;
        if (cfg_rev_src) begin
            nxt_rev = revolution + REV_W'(roll_over) - REV_W'(roll_under);
        end else if (idx_rise) begin
            nxt_rev = last_dir ? revolution + REV_W'(1) : revolution - REV_W'(1);
        end
        if (sw_init) nxt_rev = '0;
    end

    // Signed step for the difference counter, restarted by a read.
    always_comb begin
        if (step_up)      step_val = DIFF_W'(1);
        else if (step_dn) step_val = '1;
        else              step_val = '0;
        nxt_diff = rd_diff ? step_val : pos_diff + step_val;
    end

    // Counter and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            position   <= '0;
            revolution <= '0;
            pos_diff   <= '0;
            last_dir   <= 1'b0;
        end else begin
            position   <= nxt_pos;
            revolution <= nxt_rev;
            pos_diff   <= nxt_diff;
            if (step_up)      last_dir <= 1'b1;
            else if (step_dn) last_dir <= 1'b0;
        end
    end

    // Snapshot of pre-update counter values on a position read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_pos  <= '0;
            hold_rev  <= '0;
            hold_diff <= '0;
        end else if (rd_pos) begin
            hold_pos  <= position;
            hold_rev  <= revolution;
            hold_diff <= pos_diff;
        end
    end

    assert_init_load_R14: assert property (@(posedge clk) disable iff (!rst_n)
        sw_init |=> (position == $past(cfg_init)) && (revolution == '0));

    assert_hold_capture_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pos |=> (hold_pos == $past(position)) && (hold_rev == $past(revolution))
                   && (hold_diff == $past(pos_diff)));

    assert_diff_restart_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_diff && !step_up && !step_dn) |=> (pos_diff == '0));

    assert_dir_up_R11: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |=> last_dir);

endmodule

// File: rtl/qpos_counter.sv
// Module: top of the quadrature position counter.
// Assumes filtered, clock-synchronous encoder inputs and static-enough
// configuration. Ties the decoder, trigger edge detectors and counters
// together, and owns the compare pulse, sticky flags and interrupt.
module qpos_counter #(
    parameter int POS_W  = 32,
    parameter int REV_W  = 16,
    parameter int DIFF_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enc_a,
    input  logic                           enc_b,
    input  logic                           enc_idx,
    input  logic                           enc_home,
    input  logic                           cfg_reverse,
    input  logic                           cfg_stepdir,
    input  logic                           cfg_mod_en,
    input  logic                           cfg_rev_src,
    input  logic                           cfg_match_on_read,
    input  logic [1:0]                     cfg_idx_mode,
    input  logic [1:0]                     cfg_home_mode,
    input  logic [POS_W-1:0]               cfg_init,
    input  logic [POS_W-1:0]               cfg_mod,
    input  logic [POS_W-1:0]               cfg_cmp,
    input  logic [qpos_pkg::NUM_FLAGS-1:0] irq_en,
    input  logic                           sw_init,
    input  logic                           rd_pos,
    input  logic                           rd_diff,
    input  logic [qpos_pkg::NUM_FLAGS-1:0] flag_clr,
    output logic [POS_W-1:0]               position,
    output logic [REV_W-1:0]               revolution,
    output logic [DIFF_W-1:0]              pos_diff,
    output logic [POS_W-1:0]               hold_pos,
    output logic [REV_W-1:0]               hold_rev,
    output logic [DIFF_W-1:0]              hold_diff,
    output logic                           last_dir,
    output logic                           posmatch,
    output logic [qpos_pkg::NUM_FLAGS-1:0] flags,
    output logic                           irq
);
    import qpos_pkg::*;

    logic                 step_up, step_dn;
    logic [NUM_TRIG-1:0]  trg_sig, trg_rise, trg_fall, trg_fire;
    logic [1:0]           trg_mode [NUM_TRIG];
    logic                 roll_over, roll_under;
    logic                 eq_now, eq_q, match_evt;
    logic [NUM_FLAGS-1:0] flag_set;

    qpos_step_decode u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .enc_a       (enc_a),
        .enc_b       (enc_b),
        .cfg_stepdir (cfg_stepdir),
        .cfg_reverse (cfg_reverse),
        .step_up     (step_up),
        .step_dn     (step_dn)
    );

    // Route the trigger inputs and their modes into per-channel arrays.
    always_comb begin
        trg_sig[TRG_HOME]   = enc_home;
        trg_sig[TRG_INDEX]  = enc_idx;
        trg_mode[TRG_HOME]  = cfg_home_mode;
        trg_mode[TRG_INDEX] = cfg_idx_mode;
    end

    for (genvar ch = 0; ch < NUM_TRIG; ch++) begin : g_trig
        qpos_edge_det u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .sig   (trg_sig[ch]),
            .rise  (trg_rise[ch]),
            .fall  (trg_fall[ch])
        );
        // Fire on the edge the channel's mode selects.
        assign trg_fire[ch] = ((trg_mode[ch] == TRIG_RISE) && trg_rise[ch])
                           || ((trg_mode[ch] == TRIG_FALL) && trg_fall[ch]);
    end

    qpos_core #(
        .POS_W  (POS_W),
        .REV_W  (REV_W),
        .DIFF_W (DIFF_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_up     (step_up),
        .step_dn     (step_dn),
        .trig_load   (|trg_fire),
        .idx_rise    (trg_rise[TRG_INDEX]),
        .sw_init     (sw_init),
        .rd_pos      (rd_pos),
        .rd_diff     (rd_diff),
        .cfg_mod_en  (cfg_mod_en),
        .cfg_rev_src (cfg_rev_src),
        .cfg_init    (cfg_init),
        .cfg_mod     (cfg_mod),
        .position    (position),
        .revolution  (revolution),
        .pos_diff    (pos_diff),
        .hold_pos    (hold_pos),
        .hold_rev    (hold_rev),
        .hold_diff   (hold_diff),
        .last_dir    (last_dir),
        .roll_over   (roll_over),
        .roll_under  (roll_under)
    );

    // Compare event: entering equality, or a counter read.
    always_comb begin
        eq_now    = (position == cfg_cmp);
        match_evt = cfg_match_on_read ? (rd_pos || rd_diff) : (eq_now && !eq_q);
    end

    // Register the compare pulse and the previous equality state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_q     <= 1'b0;
            posmatch <= 1'b0;
        end else begin
            eq_q     <= eq_now;
            posmatch <= match_evt;
        end
    end

    // Collect flag set events in flag bit order.
    always_comb begin
        flag_set            = '0;
        flag_set[FLG_HOME]  = trg_fire[TRG_HOME];
        flag_set[FLG_INDEX] = trg_fire[TRG_INDEX];
        flag_set[FLG_CMP]   = match_evt;
        flag_set[FLG_ROVR]  = roll_over;
        flag_set[FLG_RUND]  = roll_under;
    end

    // Sticky flags: clear by writing one, a set in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | flag_set;
    end

    // Interrupt from enabled flags.
    always_comb irq = |(flags & irq_en);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

    assert_match_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (posmatch && !cfg_match_on_read) |=> !posmatch);

    assert_match_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        posmatch |-> flags[FLG_CMP]);

endmodule

// File: tb/qpos_counter_test.sv
module qpos_counter_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enc_a, enc_b, enc_idx, enc_home;
    logic        cfg_reverse, cfg_stepdir, cfg_mod_en, cfg_rev_src, cfg_match_on_read;
    logic [1:0]  cfg_idx_mode, cfg_home_mode;
    logic [31:0] cfg_init, cfg_mod, cfg_cmp;
    logic [4:0]  irq_en, flag_clr, flags;
    logic        sw_init, rd_pos, rd_diff;
    logic [31:0] position, hold_pos;
    logic [15:0] revolution, pos_diff, hold_rev, hold_diff;
    logic        last_dir, posmatch, irq;

    int n_checks = 0;
    int n_errors = 0;
    logic [1:0] qs = 2'd0;

    always #2 clk = ~clk;

    qpos_counter uut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .enc_idx(enc_idx), .enc_home(enc_home),
        .cfg_reverse(cfg_reverse), .cfg_stepdir(cfg_stepdir),
        .cfg_mod_en(cfg_mod_en), .cfg_rev_src(cfg_rev_src),
        .cfg_match_on_read(cfg_match_on_read),
        .cfg_idx_mode(cfg_idx_mode), .cfg_home_mode(cfg_home_mode),
        .cfg_init(cfg_init), .cfg_mod(cfg_mod), .cfg_cmp(cfg_cmp),
        .irq_en(irq_en), .sw_init(sw_init), .rd_pos(rd_pos), .rd_diff(rd_diff),
        .flag_clr(flag_clr), .position(position), .revolution(revolution),
        .pos_diff(pos_diff), .hold_pos(hold_pos), .hold_rev(hold_rev),
        .hold_diff(hold_diff), .last_dir(last_dir), .posmatch(posmatch),
        .flags(flags), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive_qs();
        enc_a = (qs == 2'd1) || (qs == 2'd2);
        enc_b = qs[1];
    endtask

    task automatic quad(input bit up);
        qs = up ? qs + 2'd1 : qs - 2'd1;
        drive_qs();
        tick();
    endtask

    task automatic do_init(input logic [31:0] v);
        cfg_init = v; sw_init = 1'b1; rd_diff = 1'b1;
        tick();
        sw_init = 1'b0; rd_diff = 1'b0;
    endtask

    task automatic clear_flags();
        flag_clr = 5'h1f; tick(); flag_clr = 5'h00;
    endtask

    task automatic t_reset();
        check("R10", "reset position", position, 0);
        check("R10", "reset revolution", revolution, 0);
        check("R13", "reset diff", pos_diff, 0);
        check("R10", "reset flags", flags, 0);
        check("R10", "reset irq", irq, 0);
        check("R8", "reset posmatch", posmatch, 0);
    endtask

    task automatic t_quad();
        do_init(0);
        repeat (4) quad(1'b1);
        check("R1", "up walk position", position, 4);
        check("R11", "last dir up", last_dir, 1);
        check("R13", "diff after 4 up", pos_diff, 4);
        quad(1'b0);
        check("R1", "down step position", position, 3);
        check("R11", "last dir down", last_dir, 0);
        quad(1'b1);
        check("R1", "back up position", position, 4);
    endtask

    task automatic t_illegal();
        qs = qs + 2'd2; drive_qs(); tick();
        check("R2", "double change 1", position, 4);
        qs = qs + 2'd2; drive_qs(); tick();
        check("R2", "double change 2", position, 4);
        check("R2", "diff unchanged", pos_diff, 4);
    endtask

    task automatic t_reverse();
        cfg_reverse = 1'b1;
        quad(1'b1); quad(1'b1);
        check("R4", "reverse up walk", position, 2);
        check("R4", "reverse last dir", last_dir, 0);
        quad(1'b0); quad(1'b0);
        check("R4", "reverse down walk", position, 4);
        cfg_reverse = 1'b0;
    endtask

    task automatic t_stepdir();
        qs = 2'd0; drive_qs(); tick();
        cfg_stepdir = 1'b1;
        do_init(0);
        repeat (3) begin enc_a = ~enc_a; tick(); end
        check("R3", "A edges B low", position, 3);
        enc_b = 1'b1; tick();
        check("R3", "B change alone", position, 3);
        repeat (2) begin enc_a = ~enc_a; tick(); end
        check("R3", "A edges B high", position, 1);
        enc_b = 1'b0; tick();
        enc_a = 1'b0; tick();
        check("R3", "falling A counts", position, 2);
        cfg_reverse = 1'b1;
        enc_a = 1'b1; tick();
        check("R4", "stepdir reversed", position, 1);
        enc_a = 1'b0; tick();
        cfg_reverse = 1'b0;
        cfg_stepdir = 1'b0;
        qs = 2'd0;
    endtask

    task automatic t_modulus();
        cfg_mod_en = 1'b1; cfg_mod = 13; cfg_rev_src = 1'b1; irq_en = 5'h08;
        do_init(10);
        clear_flags();
        repeat (3) quad(1'b1);
        check("R5", "reach modulus", position, 13);
        check("R10", "no irq yet", irq, 0);
        quad(1'b1);
        check("R5", "roll-over reload", position, 10);
        check("R5", "roll-over flag", flags, 5'h08);
        check("R6", "rev from roll-over", revolution, 1);
        check("R10", "irq enabled flag", irq, 1);
        flag_clr = 5'h08; tick(); flag_clr = 5'h00;
        check("R10", "w1c clears", flags, 0);
        check("R10", "irq drops", irq, 0);
        quad(1'b0);
        check("R5", "roll-under reload", position, 13);
        check("R5", "roll-under flag", flags, 5'h10);
        check("R6", "rev from roll-under", revolution, 0);
        check("R10", "irq masked flag", irq, 0);
        flag_clr = 5'h18; quad(1'b1); flag_clr = 5'h00;
        check("R10", "set wins over clear", flags, 5'h08);
        check("R6", "rev again", revolution, 1);
        sw_init = 1'b1; quad(1'b1); sw_init = 1'b0;
        check("R14", "init beats count", position, 10);
        check("R14", "init clears rev", revolution, 0);
        cfg_mod_en = 1'b0; cfg_rev_src = 1'b0; irq_en = 5'h00;
        clear_flags();
    endtask

    task automatic t_wrap();
        do_init(0);
        clear_flags();
        quad(1'b0);
        check("R5", "plain wrap down", position, 32'hFFFF_FFFF);
        check("R5", "plain roll-under", flags, 5'h10);
        quad(1'b1);
        check("R5", "plain wrap up", position, 0);
        check("R5", "plain roll-over", flags, 5'h18);
        clear_flags();
    endtask

    task automatic t_index();
        do_init(50);
        quad(1'b1);
        cfg_idx_mode = 2'd1;
        enc_idx = 1'b1; tick();
        check("R7", "index rise reload", position, 50);
        check("R7", "index flag", flags, 5'h02);
        check("R6", "index rev up", revolution, 1);
        quad(1'b1);
        enc_idx = 1'b0; tick();
        check("R7", "fall ignored in rise mode", position, 51);
        clear_flags();
        cfg_idx_mode = 2'd2;
        enc_idx = 1'b1; tick();
        check("R7", "rise ignored in fall mode", position, 51);
        check("R7", "no flag on rise", flags, 0);
        check("R6", "rev counts any mode", revolution, 2);
        enc_idx = 1'b0; tick();
        check("R7", "fall reload", position, 50);
        check("R7", "fall flag", flags, 5'h02);
        clear_flags();
        cfg_idx_mode = 2'd0;
        quad(1'b1);
        enc_idx = 1'b1; tick();
        check("R7", "mode off no reload", position, 51);
        check("R7", "mode off no flag", flags, 0);
        check("R6", "rev third", revolution, 3);
        enc_idx = 1'b0; tick();
        quad(1'b0);
        enc_idx = 1'b1; tick();
        check("R6", "rev down with last dir", revolution, 2);
        enc_idx = 1'b0; tick();
    endtask

    task automatic t_home();
        cfg_home_mode = 2'd2;
        quad(1'b1);
        enc_home = 1'b1; tick();
        check("R7", "home rise ignored", position, 51);
        enc_home = 1'b0; tick();
        check("R7", "home fall reload", position, 50);
        check("R7", "home flag", flags, 5'h01);
        cfg_home_mode = 2'd0;
        clear_flags();
    endtask

    task automatic t_match();
        cfg_cmp = 51;
        quad(1'b1);
        check("R8", "no pulse same cycle", posmatch, 0);
        tick();
        check("R8", "pulse after equal", posmatch, 1);
        check("R8", "compare flag", flags, 5'h04);
        tick();
        check("R8", "pulse one cycle", posmatch, 0);
        cfg_cmp = 32'h7FFF_0000;
        clear_flags();
        cfg_match_on_read = 1'b1;
        rd_pos = 1'b1; tick(); rd_pos = 1'b0;
        check("R9", "pulse on pos read", posmatch, 1);
        check("R9", "flag on read", flags, 5'h04);
        tick();
        check("R9", "read pulse ends", posmatch, 0);
        rd_diff = 1'b1; tick(); rd_diff = 1'b0;
        check("R9", "pulse on diff read", posmatch, 1);
        cfg_match_on_read = 1'b0;
        clear_flags();
    endtask

    task automatic t_hold();
        do_init(0);
        repeat (3) quad(1'b1);
        rd_pos = 1'b1; quad(1'b1); rd_pos = 1'b0;
        check("R12", "hold position pre-count", hold_pos, 3);
        check("R12", "hold diff", hold_diff, 3);
        check("R12", "hold rev", hold_rev, 0);
        check("R12", "live position", position, 4);
        rd_diff = 1'b1; tick(); rd_diff = 1'b0;
        check("R13", "diff restarted", pos_diff, 0);
        rd_diff = 1'b1; quad(1'b1); rd_diff = 1'b0;
        check("R13", "diff with read-cycle count", pos_diff, 1);
        quad(1'b0);
        check("R13", "diff signed accumulate", pos_diff, 0);
    endtask

    initial begin
        #400000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        enc_a = 0; enc_b = 0; enc_idx = 0; enc_home = 0;
        cfg_reverse = 0; cfg_stepdir = 0; cfg_mod_en = 0; cfg_rev_src = 0;
        cfg_match_on_read = 0; cfg_idx_mode = 0; cfg_home_mode = 0;
        cfg_init = 0; cfg_mod = 0; cfg_cmp = 32'h7FFF_0000;
        irq_en = 0; flag_clr = 0; sw_init = 0; rd_pos = 0; rd_diff = 0;
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_quad();
        t_illegal();
        t_reverse();
        t_stepdir();
        t_modulus();
        t_wrap();
        t_index();
        t_home();
        t_match();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule